// File: doc/BRIEF.md
# Processor Subsystem Power-Up Sequencer

This block is a hardware state machine that takes a processor subsystem from a powered-down, held-in-reset condition to running code, triggered by one start pulse. It drives every power-control line of the subsystem in a fixed order. First it asserts the resets and halts the core. It then brings up the reference clock and checks that the clock comes up. Next it turns on the head switch and bypasses the regulator. It lifts the clamps, wakes the memories bank by bank, and finally lets the core fetch from a latched boot vector.

Fixed delays are measured with an external one-microsecond tick. A delay of "one microsecond" ends on the second tick seen after the step, so it always lasts at least one full tick period. While the clock-off status stays high, the block counts ticks. If the reference clock does not come up within the poll limit, the sequencer stops, raises a sticky error and freezes all outputs until reset. On success it gives a one-cycle done pulse in the same cycle the core is released. A later start in idle runs the sequence again.

Top module: `pwrup_seq`

## Requirements
- R1: After reset: core_rst, bus_rst, core_halt, ref_clk_en, head_sw_on, reg_bypass, mem_stby_off, sleep_ret_off, core_clk_en and every bank_pwr bit are 0. cmem_clamp, wline_clamp and io_clamp are 1. busy, done, timeout_err and boot_vec are 0.
- R2: A start seen in idle loads boot_vec with boot_addr[31:4] on that edge. core_rst, bus_rst and core_halt all rise together on the next edge, and busy is high from then on.
- R3: ref_clk_en rises one cycle after the resets. From the next cycle on, the block polls refclk_off.
- R4: The first poll cycle that sees refclk_off low sets head_sw_on on that edge.
- R5: If refclk_off is still high on the POLL_LIMIT-th us_tick during polling, timeout_err rises on that edge and busy falls. All outputs then hold their values and start has no effect until reset.
- R6: reg_bypass rises on the edge of the second us_tick after head_sw_on rose.
- R7: cmem_clamp falls one cycle after reg_bypass rises. mem_stby_off and sleep_ret_off rise together one cycle after that.
- R8: bank_pwr bits turn on one per step, from bit NUM_BANKS-1 down to bit 0. The first bank turns on one cycle after the retention step. Each later bank turns on one cycle after the second us_tick that follows the previous bank.
- R9: wline_clamp falls one cycle after the second us_tick that follows bank 0. io_clamp falls on the next cycle.
- R10: core_rst falls one cycle after io_clamp falls, and core_clk_en rises on the cycle after that. One cycle later core_halt falls, done pulses high for exactly that cycle, and busy falls.
- R11: A start while busy is ignored. boot_vec keeps its value, and the sequence timing and the single done pulse are unchanged.
- R12: A start in idle after a completed sequence reloads boot_vec, reasserts core_rst and core_halt, and runs through to a new done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start request pulse |
| boot_addr | input | 32 | Boot byte address |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| refclk_off | input | 1 | High while the reference clock is still off |
| core_rst | output | 1 | Core reset |
| bus_rst | output | 1 | Bus reset enable |
| core_halt | output | 1 | Holds the core from executing |
| ref_clk_en | output | 1 | Reference clock branch enable |
| head_sw_on | output | 1 | Block head switch enable |
| reg_bypass | output | 1 | Regulator bypass |
| cmem_clamp | output | 1 | Compiler memory clamp |
| wline_clamp | output | 1 | Memory wordline clamp |
| io_clamp | output | 1 | IO clamp |
| mem_stby_off | output | 1 | Data memory standby release |
| sleep_ret_off | output | 1 | Sleep retention release |
| bank_pwr | output | 20 | Per-bank memory power |
| core_clk_en | output | 1 | Core clock enable |
| boot_vec | output | 28 | Latched boot vector (address / 16) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout_err | output | 1 | Sticky reference clock timeout |

## Verification
The bench sweeps how many ticks the reference clock takes to come up. The sweep includes the last count that still succeeds and the first count that times out, so an off-by-one poll counter shows up as an early abort or a missing abort. Every step is timestamped in cycles and in ticks. This catches a design that shortens a microsecond wait to a single tick, powers two banks at once or in ascending order, or swaps the clamp releases. Starts are issued while the sequence runs, after it completes and after a timeout. A design that relatches the vector, restarts mid-way or leaves the frozen state would change the captured timing or values.

// File: rtl/pwrup_seq.sv
module pwrup_seq #(
  parameter int NUM_BANKS  = 20,
  parameter int POLL_LIMIT = 200,
  parameter int ADDR_W     = 32,
  parameter int VEC_SHIFT  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  logic [ADDR_W-1:0]             boot_addr,
  input  logic                          us_tick,
  input  logic                          refclk_off,
  output logic                          core_rst,
  output logic                          bus_rst,
  output logic                          core_halt,
  output logic                          ref_clk_en,
  output logic                          head_sw_on,
  output logic                          reg_bypass,
  output logic                          cmem_clamp,
  output logic                          wline_clamp,
  output logic                          io_clamp,
  output logic                          mem_stby_off,
  output logic                          sleep_ret_off,
  output logic [NUM_BANKS-1:0]          bank_pwr,
  output logic                          core_clk_en,
  output logic [ADDR_W-VEC_SHIFT-1:0]   boot_vec,
  output logic                          busy,
  output logic                          done,
  output logic                          timeout_err
);

  localparam int IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int CNT_W = $clog2(POLL_LIMIT + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_ASSERT, S_REFCLK, S_POLL, S_HSW, S_MCLAMP, S_RET,
    S_BANK, S_BANKW, S_WL, S_IO, S_CREL, S_CLKON, S_GO, S_FAIL
  } st_t;

  st_t              st;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] poll_cnt;
  logic             tick_seen;
  logic             wait_hit;

  assign wait_hit = us_tick & tick_seen;
  assign busy     = (st != S_IDLE) && (st != S_FAIL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st            <= S_IDLE;
      idx           <= '0;
      poll_cnt      <= '0;
      tick_seen     <= 1'b0;
      core_rst      <= 1'b0;
      bus_rst       <= 1'b0;
      core_halt     <= 1'b0;
      ref_clk_en    <= 1'b0;
      head_sw_on    <= 1'b0;
      reg_bypass    <= 1'b0;
      cmem_clamp    <= 1'b1;
      wline_clamp   <= 1'b1;
      io_clamp      <= 1'b1;
      mem_stby_off  <= 1'b0;
      sleep_ret_off <= 1'b0;
      bank_pwr      <= '0;
      core_clk_en   <= 1'b0;
      boot_vec      <= '0;
      done          <= 1'b0;
      timeout_err   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          boot_vec <= boot_addr[ADDR_W-1:VEC_SHIFT];
          st       <= S_ASSERT;
        end
        S_ASSERT: begin
          core_rst  <= 1'b1;
          bus_rst   <= 1'b1;
          core_halt <= 1'b1;
          st        <= S_REFCLK;
        end
        S_REFCLK: begin
          ref_clk_en <= 1'b1;
          poll_cnt   <= '0;
          st         <= S_POLL;
        end
        S_POLL: begin
          if (!refclk_off) begin
            head_sw_on <= 1'b1;
            tick_seen  <= 1'b0;
            st         <= S_HSW;
          end else if (us_tick) begin
            if (poll_cnt == CNT_W'(POLL_LIMIT - 1)) begin
              timeout_err <= 1'b1;
              st          <= S_FAIL;
            end else begin
              poll_cnt <= poll_cnt + 1'b1;
            end
          end
        end
        S_HSW: begin
          if (us_tick) tick_seen <= ~tick_seen;
          if (wait_hit) begin
            reg_bypass <= 1'b1;
            st         <= S_MCLAMP;
          end
        end
        S_MCLAMP: begin
          cmem_clamp <= 1'b0;
          st         <= S_RET;
        end
        S_RET: begin
          mem_stby_off  <= 1'b1;
          sleep_ret_off <= 1'b1;
          idx           <= IDX_W'(NUM_BANKS - 1);
          st            <= S_BANK;
        end
        S_BANK: begin
          bank_pwr[idx] <= 1'b1;
          tick_seen     <= 1'b0;
          st            <= S_BANKW;
        end
        S_BANKW: begin
          if (us_tick) tick_seen <= ~tick_seen;
          if (wait_hit) begin
            if (idx == '0) st <= S_WL;
            else begin
              idx <= idx - 1'b1;
              st  <= S_BANK;
            end
          end
        end
        S_WL: begin
          wline_clamp <= 1'b0;
          st          <= S_IO;
        end
        S_IO: begin
          io_clamp <= 1'b0;
          st       <= S_CREL;
        end
        S_CREL: begin
          core_rst <= 1'b0;
          st       <= S_CLKON;
        end
        S_CLKON: begin
          core_clk_en <= 1'b1;
          st          <= S_GO;
        end
        S_GO: begin
          core_halt <= 1'b0;
          done      <= 1'b1;
          st        <= S_IDLE;
        end
        default: ;
      endcase
    end
  end

  // R4: head switch only with the reference clock branch on
  a_r4_hs_needs_ref: assert property (@(posedge clk) disable iff (!rst_n)
    head_sw_on |-> ref_clk_en);

  // R6: regulator bypass only behind the head switch
  a_r6_bypass_after_hs: assert property (@(posedge clk) disable iff (!rst_n)
    reg_bypass |-> head_sw_on);

  // R8: at most one bank turns on per cycle
  a_r8_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(bank_pwr & ~$past(bank_pwr)) <= 1);

  // R9: IO clamp lifted only after the wordline clamp and all banks
  a_r9_io_after_wl: assert property (@(posedge clk) disable iff (!rst_n)
    !io_clamp |-> (!wline_clamp && bank_pwr[0]));

  // R10: done coincides with the core leaving halt, clock on and reset off
  a_r10_done_release: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(core_halt) && !core_halt && core_clk_en && !core_rst));

  // R5: timeout is sticky and freezes the outputs
  a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |=> (timeout_err && !busy && $stable(bank_pwr) && $stable(head_sw_on)
                     && $stable(core_rst) && $stable(boot_vec) && !done));

endmodule

// File: tb/pwrup_seq_tb.sv
`timescale 1ns/1ps
module pwrup_seq_tb_top;
  localparam int NB = 20;
  localparam int PL = 200;
  localparam int TD = 3;
  localparam int WD = 190000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, us_tick = 1'b0, refclk_off = 1'b1;
  logic [31:0] boot_addr = '0;
  logic core_rst, bus_rst, core_halt, ref_clk_en, head_sw_on, reg_bypass;
  logic cmem_clamp, wline_clamp, io_clamp, mem_stby_off, sleep_ret_off;
  logic [NB-1:0] bank_pwr;
  logic core_clk_en, busy, done, timeout_err;
  logic [27:0] boot_vec;

  pwrup_seq dut_i (.*);

  int checks = 0, errors = 0;
  int cyc = 0, tick_cnt = 0;
  logic et = 0, etp = 0;

  always @(posedge clk) begin
    cyc++;
    if (us_tick) tick_cnt++;
    etp = et;
    et  = us_tick;
    if (cyc == WD) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, WD);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int dv = 0;
    forever begin
      @(negedge clk);
      us_tick = (dv == TD - 1);
      dv = (dv == TD - 1) ? 0 : dv + 1;
    end
  end

  int t_rst, t_bus, t_halt, t_ref, k_ref, t_hs, k_hs, t_ldo, k_ldo, e_ldo;
  int t_mcl, t_stb, t_slp, t_wl, k_wl, p_wl, t_io, t_crel, t_clk, t_go;
  int t_done, done_n, t_to, k_to, e_to, nseq;
  int bseq[64], bt[64], bk[64], bp[64];
  logic p_rst, p_bus, p_halt, p_ref, p_hs, p_ldo, p_mcl, p_stb, p_slp;
  logic p_wlc, p_io, p_clk, p_to;
  logic [NB-1:0] p_bank;

  task automatic clear_stamps();
    t_rst = -1; t_bus = -1; t_halt = -1; t_ref = -1; k_ref = -1; t_hs = -1; k_hs = -1;
    t_ldo = -1; k_ldo = -1; e_ldo = -1; t_mcl = -1; t_stb = -1; t_slp = -1;
    t_wl = -1; k_wl = -1; p_wl = -1; t_io = -1; t_crel = -1; t_clk = -1; t_go = -1;
    t_done = -1; done_n = 0; t_to = -1; k_to = -1; e_to = -1; nseq = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (core_rst && !p_rst) t_rst = cyc;
      if (!core_rst && p_rst) t_crel = cyc;
      if (bus_rst && !p_bus) t_bus = cyc;
      if (core_halt && !p_halt) t_halt = cyc;
      if (!core_halt && p_halt) t_go = cyc;
      if (ref_clk_en && !p_ref) begin t_ref = cyc; k_ref = tick_cnt; end
      if (head_sw_on && !p_hs) begin t_hs = cyc; k_hs = tick_cnt; end
      if (reg_bypass && !p_ldo) begin t_ldo = cyc; k_ldo = tick_cnt; e_ldo = et; end
      if (!cmem_clamp && p_mcl) t_mcl = cyc;
      if (mem_stby_off && !p_stb) t_stb = cyc;
      if (sleep_ret_off && !p_slp) t_slp = cyc;
      if (!wline_clamp && p_wlc) begin t_wl = cyc; k_wl = tick_cnt; p_wl = etp; end
      if (!io_clamp && p_io) t_io = cyc;
      if (core_clk_en && !p_clk) t_clk = cyc;
      if (timeout_err && !p_to) begin t_to = cyc; k_to = tick_cnt; e_to = et; end
      if (done) begin done_n++; t_done = cyc; end
      for (int b = 0; b < NB; b++)
        if (bank_pwr[b] && !p_bank[b] && nseq < 64) begin
          bseq[nseq] = b; bt[nseq] = cyc; bk[nseq] = tick_cnt; bp[nseq] = etp; nseq++;
        end
    end
    p_rst = core_rst; p_bus = bus_rst; p_halt = core_halt; p_ref = ref_clk_en;
    p_hs = head_sw_on; p_ldo = reg_bypass; p_mcl = cmem_clamp; p_stb = mem_stby_off;
    p_slp = sleep_ret_off; p_wlc = wline_clamp; p_io = io_clamp; p_clk = core_clk_en;
    p_to = timeout_err; p_bank = bank_pwr;
  end

  task automatic chk(input string rq, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #0.2;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0; refclk_off = 1'b1;
    repeat (3) step();
    rst_n = 1'b1;
    clear_stamps();
    step();
  endtask

  task automatic pulse_start(input logic [31:0] a, output int s);
    boot_addr = a; start = 1'b1;
    step();
    start = 1'b0;
    s = cyc;
  endtask

  task automatic release_after(input int k);
    int g = 0;
    while (t_ref < 0 && g < 100) begin step(); g++; end
    while (tick_cnt - k_ref < k && !timeout_err && g < 5000) begin step(); g++; end
  endtask

  task automatic check_tail(input int c_rel);
    chk("R4 head switch edge", t_hs, c_rel + 1);
    chk("R6 bypass tick gap", k_ldo - k_hs, 2);
    chk("R6 bypass on tick edge", e_ldo, 1);
    chk("R7 mem clamp release", t_mcl, t_ldo + 1);
    chk("R7 standby release", t_stb, t_mcl + 1);
    chk("R7 retention release", t_slp, t_mcl + 1);
    chk("R8 bank count", nseq, NB);
    chk("R8 first bank time", bt[0], t_stb + 1);
    for (int j = 0; j < NB && j < nseq; j++) begin
      chk("R8 bank order", bseq[j], NB - 1 - j);
      if (j > 0) begin
        chk("R8 bank tick gap", bk[j] - bk[j-1], 2);
        chk("R8 bank after tick", bp[j], 1);
      end
    end
    if (nseq > 0) chk("R9 wordline tick gap", k_wl - bk[nseq-1], 2);
    chk("R9 wordline after tick", p_wl, 1);
    chk("R9 io after wordline", t_io, t_wl + 1);
    chk("R10 core reset release", t_crel, t_io + 1);
    chk("R10 core clock", t_clk, t_crel + 1);
    chk("R10 halt release", t_go, t_clk + 1);
    chk("R10 done with release", t_done, t_go);
    chk("R10 single done", done_n, 1);
    chk("R10 busy low", busy, 0);
  endtask

  task automatic run_ok(input logic [31:0] a, input int k, input bit poke);
    int s, c_rel, g;
    do_reset();
    pulse_start(a, s);
    chk("R2 boot vector", boot_vec, a >> 4);
    step();
    chk("R2 core reset edge", t_rst, s + 1);
    chk("R2 bus reset edge", t_bus, s + 1);
    chk("R2 halt edge", t_halt, s + 1);
    chk("R2 busy", busy, 1);
    release_after(k);
    chk("R3 ref clock edge", t_ref, t_rst + 1);
    chk("R5 no early timeout", timeout_err, 0);
    refclk_off = 1'b0;
    c_rel = cyc;
    g = 0;
    if (poke) begin
      while (nseq < 5 && g < 3000) begin step(); g++; end
      pulse_start(~a, s);
      step();
      chk("R11 vector kept", boot_vec, a >> 4);
    end
    while (done_n == 0 && g < 3000) begin step(); g++; end
    repeat (4) step();
    check_tail(c_rel);
    if (poke) chk("R11 vector kept at end", boot_vec, a >> 4);
  endtask

  initial begin
    int s, g;
    rst_n = 1'b0;
    repeat (3) step();
    // R1 reset values
    chk("R1 core_rst", core_rst, 0);
    chk("R1 bus_rst", bus_rst, 0);
    chk("R1 core_halt", core_halt, 0);
    chk("R1 ref_clk_en", ref_clk_en, 0);
    chk("R1 head_sw_on", head_sw_on, 0);
    chk("R1 reg_bypass", reg_bypass, 0);
    chk("R1 clamps", {cmem_clamp, wline_clamp, io_clamp}, 3'b111);
    chk("R1 retention", {mem_stby_off, sleep_ret_off}, 0);
    chk("R1 banks", bank_pwr, 0);
    chk("R1 core_clk_en", core_clk_en, 0);
    chk("R1 status", {busy, done, timeout_err}, 0);
    chk("R1 boot_vec", boot_vec, 0);

    run_ok(32'hDEADBEE0, 0, 1'b0);
    run_ok(32'h1234_5678, 1, 1'b0);
    run_ok(32'h0000_0010, 2, 1'b0);
    run_ok(32'hFFFF_FFFF, 7, 1'b0);
    run_ok(32'h8000_0000, PL - 1, 1'b0);
    run_ok(32'hA5A5_5A50, 3, 1'b1);

    // R12 restart after completion
    pulse_start(32'h0BAD_F00D, s);
    chk("R12 vector reload", boot_vec, 32'h0BAD_F00D >> 4);
    step();
    chk("R12 core reset again", core_rst, 1);
    chk("R12 halt again", core_halt, 1);
    g = 0;
    while (done_n < 2 && g < 3000) begin step(); g++; end
    chk("R12 second done", done_n, 2);
    chk("R12 core running", {core_halt, core_rst, core_clk_en}, 3'b001);

    // R5 timeout
    do_reset();
    pulse_start(32'h0000_4440, s);
    release_after(PL);
    step();
    chk("R5 timeout ticks", k_to - k_ref, PL);
    chk("R5 timeout on tick edge", e_to, 1);
    chk("R5 timeout flag", timeout_err, 1);
    chk("R5 busy low", busy, 0);
    chk("R5 head switch held off", head_sw_on, 0);
    refclk_off = 1'b0;
    pulse_start(32'hFFFF_0000, s);
    repeat (40) step();
    chk("R5 flag sticky", timeout_err, 1);
    chk("R5 start ignored vector", boot_vec, 32'h0000_4440 >> 4);
    chk("R5 outputs frozen", {core_rst, core_halt, ref_clk_en, head_sw_on}, 4'b1110);
    chk("R5 no done", done_n, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule